// File: doc/BRIEF.md
# Stereo Peak-Hold Overrange Detector

This block watches the signed samples leaving a stereo ADC, one stream for the left channel and one for the right. Each channel has a valid strobe, and the block reads the sample only when that strobe is high. It takes the absolute value of each qualified sample and sorts it into one of four magnitude classes. Three magnitude thresholds set the class boundaries: the -1 dB point, the 0 dB point and the +1 dB point. The thresholds are precomputed constants given as parameters.

For each channel the block holds the highest class seen since the last clear. Both held codes appear in a read-only 8-bit debug register. Firmware reads that register to learn whether the converter input came close to full scale or passed it. The codes are cleared in two ways: a host write strobe on the register, or the power-down input. Either clear takes effect at the next clock edge. A clear has priority over a sample that arrives in the same cycle.

The reset is asynchronous and active low. Its release is synchronised to the clock inside the block.

Top module: `range_peak_top`

## Requirements
- R1: After reset the debug register reads 0x00. Bits [7:4] read zero at all times.
- R2: A sample is classified with inclusive upper bounds. Magnitude at or below TH_M1DB gives code 00. Above TH_M1DB and at or below TH_0DB gives 01. Above TH_0DB and at or below TH_P1DB gives 10. Above TH_P1DB gives 11.
- R3: The magnitude is the absolute value of the two's-complement sample. The most negative sample value is treated as the largest positive magnitude, 2^(W-1)-1.
- R4: A held code changes only to a higher value. A qualified sample of a lower or equal class leaves it unchanged.
- R5: When host_wr_i is high at a clock edge, both held codes become 00.
- R6: When pwr_down_i is high at a clock edge, both held codes become 00.
- R7: If a clear and a qualified sample occur in the same cycle, the clear wins and the sample is discarded. Samples are evaluated again from the next cycle.
- R8: A sample affects its channel's code only when that channel's valid strobe is high. The two channels are independent.
- R9: The left code occupies bits [1:0] of the debug register and the right code occupies bits [3:2]. The register updates at the clock edge that samples the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_down_i | input | 1 | Power-down, clears both codes |
| host_wr_i | input | 1 | Host write strobe to the debug register, clears both codes |
| left_vld_i | input | 1 | Left sample valid |
| left_smp_i | input | W | Left signed sample |
| right_vld_i | input | 1 | Right sample valid |
| right_smp_i | input | W | Right signed sample |
| dbg_reg_o | output | 8 | Debug register: {4'b0, right code, left code} |

## Verification
The assertions check the following on every cycle:
- No held code ever falls except right after a clear.
- A host write or a power-down empties both codes one edge later.
- A channel whose strobe is low keeps its code.
- The upper nibble stays zero.

Some behaviour can only be shown by the bench's scenarios, because it depends on the data: the exact class boundaries, where each threshold is inclusive; the saturation of the most negative sample; and the rule that a discarded sample in a clear cycle does not reappear.

// File: rtl/range_peak_pkg.sv
package range_peak_pkg;
  typedef enum logic [1:0] {
    RNG_LOW  = 2'b00,
    RNG_NEAR = 2'b01,
    RNG_FULL = 2'b10,
    RNG_OVER = 2'b11
  } rng_code_t;
endpackage

// File: rtl/range_peak_rst_sync.sv
module range_peak_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/range_peak_classify.sv
module range_peak_classify
  import range_peak_pkg::*;
#(
  parameter int unsigned W       = 16,
  parameter int unsigned TH_M1DB = 26000,
  parameter int unsigned TH_0DB  = 29000,
  parameter int unsigned TH_P1DB = 32000
) (
  input  logic [W-1:0] smp_i,
  output rng_code_t    cls_o
);
  localparam logic [W-1:0] MAX_MAG = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] LIM_LO  = TH_M1DB[W-1:0];
  localparam logic [W-1:0] LIM_MID = TH_0DB[W-1:0];
  localparam logic [W-1:0] LIM_HI  = TH_P1DB[W-1:0];

  logic [W-1:0] mag;

  always_comb begin
    if (smp_i == MIN_NEG)   mag = MAX_MAG;
    else if (smp_i[W-1])    mag = (~smp_i) + 1'b1;
    else                    mag = smp_i;
  end

  always_comb begin
    if (mag <= LIM_LO)       cls_o = RNG_LOW;
    else if (mag <= LIM_MID) cls_o = RNG_NEAR;
    else if (mag <= LIM_HI)  cls_o = RNG_FULL;
    else                     cls_o = RNG_OVER;
  end
endmodule

// File: rtl/range_peak_hold.sv
module range_peak_hold
  import range_peak_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      clr_i,
  input  logic      vld_i,
  input  rng_code_t cls_i,
  output rng_code_t code_o
);
  rng_code_t code_q;
  rng_code_t code_d;
  logic      code_en;

  always_comb begin
    code_en = 1'b0;
    code_d  = code_q;
    if (clr_i) begin
      code_en = 1'b1;
      code_d  = RNG_LOW;
    end else if (vld_i && (cls_i > code_q)) begin
      code_en = 1'b1;
      code_d  = cls_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       code_q <= RNG_LOW;
    else if (code_en) code_q <= code_d;
  end

  assign code_o = code_q;
endmodule

// File: rtl/range_peak_top.sv
module range_peak_top
  import range_peak_pkg::*;
#(
  parameter int unsigned W       = 16,
  parameter int unsigned TH_M1DB = 26000,
  parameter int unsigned TH_0DB  = 29000,
  parameter int unsigned TH_P1DB = 32000,
  parameter int unsigned REG_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_down_i,
  input  logic             host_wr_i,
  input  logic             left_vld_i,
  input  logic [W-1:0]     left_smp_i,
  input  logic             right_vld_i,
  input  logic [W-1:0]     right_smp_i,
  output logic [REG_W-1:0] dbg_reg_o
);
  localparam int unsigned NCH    = 2;
  localparam int unsigned CODE_W = 2;
  localparam int unsigned USED_W = NCH * CODE_W;

  logic         rst_sync_n;
  logic         clr_all;
  logic [W-1:0] smp   [NCH];
  logic         vld   [NCH];
  rng_code_t    cls   [NCH];
  rng_code_t    code  [NCH];

  range_peak_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign clr_all = host_wr_i | pwr_down_i;
  assign smp[0]  = left_smp_i;
  assign smp[1]  = right_smp_i;
  assign vld[0]  = left_vld_i;
  assign vld[1]  = right_vld_i;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    range_peak_classify #(
      .W(W), .TH_M1DB(TH_M1DB), .TH_0DB(TH_0DB), .TH_P1DB(TH_P1DB)
    ) u_cls (
      .smp_i (smp[ch]),
      .cls_o (cls[ch])
    );

    range_peak_hold u_hold (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .clr_i  (clr_all),
      .vld_i  (vld[ch]),
      .cls_i  (cls[ch]),
      .code_o (code[ch])
    );

    assign dbg_reg_o[ch*CODE_W +: CODE_W] = code[ch];
  end

  assign dbg_reg_o[REG_W-1:USED_W] = '0;
endmodule

// File: rtl/range_peak_chk.sv
module range_peak_chk #(
  parameter int unsigned REG_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             host_wr_i,
  input logic             pwr_down_i,
  input logic             left_vld_i,
  input logic             right_vld_i,
  input logic [REG_W-1:0] dbg_reg_o
);
  assert_upper_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_reg_o[REG_W-1:4] == '0);

  assert_left_rises_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_wr_i || pwr_down_i) |=> dbg_reg_o[1:0] >= $past(dbg_reg_o[1:0]));

  assert_right_rises_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_wr_i || pwr_down_i) |=> dbg_reg_o[3:2] >= $past(dbg_reg_o[3:2]));

  assert_wr_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr_i |=> dbg_reg_o[3:0] == 4'h0);

  assert_pd_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down_i |=> dbg_reg_o[3:0] == 4'h0);

  assert_left_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!left_vld_i && !host_wr_i && !pwr_down_i) |=> $stable(dbg_reg_o[1:0]));

  assert_right_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!right_vld_i && !host_wr_i && !pwr_down_i) |=> $stable(dbg_reg_o[3:2]));
endmodule

bind range_peak_top range_peak_chk #(.REG_W(REG_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .host_wr_i   (host_wr_i),
  .pwr_down_i  (pwr_down_i),
  .left_vld_i  (left_vld_i),
  .right_vld_i (right_vld_i),
  .dbg_reg_o   (dbg_reg_o)
);

// File: tb/range_peak_top_tb_top.sv
module range_peak_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W   = 16;
  localparam int LO  = 26000;
  localparam int MID = 29000;
  localparam int HI  = 32000;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } item_t;

  logic         clk;
  logic         rst_n;
  logic         pwr_down_i;
  logic         host_wr_i;
  logic         left_vld_i;
  logic [W-1:0] left_smp_i;
  logic         right_vld_i;
  logic [W-1:0] right_smp_i;
  logic [7:0]   dbg_reg_o;

  int    n_checks;
  int    n_errors;
  item_t sb_q[$];
  logic [1:0] m_left;
  logic [1:0] m_right;
  bit    done;

  range_peak_top #(.W(W), .TH_M1DB(LO), .TH_0DB(MID), .TH_P1DB(HI)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .pwr_down_i  (pwr_down_i),
    .host_wr_i   (host_wr_i),
    .left_vld_i  (left_vld_i),
    .left_smp_i  (left_smp_i),
    .right_vld_i (right_vld_i),
    .right_smp_i (right_smp_i),
    .dbg_reg_o   (dbg_reg_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [1:0] expect_class(input int s);
    int m;
    m = (s < 0) ? -s : s;
    if (m > 32767) m = 32767;
    if (m <= LO)       return 2'd0;
    else if (m <= MID) return 2'd1;
    else if (m <= HI)  return 2'd2;
    else               return 2'd3;
  endfunction

  task automatic check_now(input logic [7:0] exp, input string tag);
    n_checks++;
    if (dbg_reg_o !== exp) begin
      n_errors++;
      $display("FAIL %s: dbg_reg_o actual=0x%02h expected=0x%02h", tag, dbg_reg_o, exp);
    end
  endtask

  task automatic drive(input bit lv, input int ls, input bit rv, input int rs,
                       input bit wr, input bit pd, input string tag);
    item_t it;
    @(negedge clk);
    left_vld_i  = lv;
    left_smp_i  = ls[W-1:0];
    right_vld_i = rv;
    right_smp_i = rs[W-1:0];
    host_wr_i   = wr;
    pwr_down_i  = pd;
    if (wr || pd) begin
      m_left  = 2'd0;
      m_right = 2'd0;
    end else begin
      if (lv && expect_class(ls) > m_left)  m_left  = expect_class(ls);
      if (rv && expect_class(rs) > m_right) m_right = expect_class(rs);
    end
    it.exp = {4'b0000, m_right, m_left};
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  initial begin
    item_t it;
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        it = sb_q.pop_front();
        check_now(it.exp, it.tag);
      end
    end
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    done = 0; n_checks = 0; n_errors = 0;
    m_left = 2'd0; m_right = 2'd0;
    rst_n = 1'b0; pwr_down_i = 0; host_wr_i = 0;
    left_vld_i = 0; left_smp_i = '0; right_vld_i = 0; right_smp_i = '0;
    repeat (3) @(posedge clk);
    #1 check_now(8'h00, "R1 reset value");
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_now(8'h00, "R1 after reset release");

    // R2 boundaries on left, inclusive upper bounds
    drive(1, LO,      0, 0, 0, 0, "R2 left at -1dB bound");
    drive(1, LO + 1,  0, 0, 0, 0, "R2 left above -1dB");
    drive(1, MID,     0, 0, 0, 0, "R2 left at 0dB bound");
    drive(1, MID + 1, 0, 0, 0, 0, "R2 left above 0dB");
    drive(1, HI,      0, 0, 0, 0, "R2 left at +1dB bound");
    drive(1, HI + 1,  0, 0, 0, 0, "R2 left above +1dB");
    // R5 host write clears
    drive(0, 0, 0, 0, 1, 0, "R5 host write clear");
    // R3 negative magnitudes
    drive(0, 0, 1, -(MID + 1), 0, 0, "R3 right negative class 10");
    drive(1, -32768, 0, 0, 0, 0, "R3 most negative saturates");
    // R4 lower class keeps held code
    drive(0, 0, 1, LO + 5, 0, 0, "R4 right lower class holds");
    drive(1, 100, 1, 0, 0, 0, "R4 small samples hold");
    // R6 power-down clears
    drive(0, 0, 0, 0, 0, 1, "R6 power-down clear");
    // R9 right only in bits [3:2]
    drive(0, 0, 1, HI + 1, 0, 0, "R9 right code position");
    drive(1, LO + 1, 0, 0, 0, 0, "R9 left code position");
    // R8 valid low ignores huge sample
    drive(0, -32768, 0, 32767, 0, 0, "R8 valid low ignored");
    // R7 clear beats same-cycle sample
    drive(1, 32767, 1, 32767, 1, 0, "R7 clear beats sample wr");
    drive(1, MID, 0, 0, 0, 0, "R7 next-cycle sample counts");
    drive(1, 32767, 1, 32767, 0, 1, "R7 clear beats sample pd");
    drive(0, 0, 1, MID + 1, 0, 0, "R8 right independent of left");
    drive(0, 0, 0, 0, 0, 0, "R1 idle");
    repeat (3) @(posedge clk);
    #2;
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule